// File: doc/BRIEF.md
# Switchable-Width Synchronous Serial Port

This block is a clocked serial shift port for a small controller. A parallel data register is loaded and read by the host, then shifted out on a serial data pin while the serial data input is shifted in, in the same transfer. A run-time mode field picks a 4-bit or 8-bit transfer and picks whether the shift clock is generated inside the block or supplied by an external master. At the end of a transfer a sticky completion flag is raised. That flag can take over the interrupt request line that otherwise follows an external active-low interrupt pin.

The four pads are shared with a general-purpose port. While the serial function is off, the pads simply carry the port's output latch. While it is on, pad 0 is released as the serial data input, pad 1 carries the serial data, and pad 2 carries the serial clock. Pad 2 is driven when the clock is generated internally and released when it comes from outside. Pad 3 always follows the port latch. An open-drain pad reads as an input while it outputs 1.

The control is a four-state machine. S_IDLE waits for a start. With the internal clock, a start moves it to S_LOW, which holds the clock low for HALF cycles and then moves to S_HIGH on a rising clock edge. S_HIGH holds the clock high for HALF cycles and then goes back to S_LOW for the next bit, or to S_IDLE after the last bit. With the external clock, a start moves it to S_EXT, which follows synchronised edges of the clock pad and returns to S_IDLE on the last rising edge.

Top module: `sio_port`

## Requirements
- R1: After reset the mode field is 0000, busy and done are 0, every pad output equals the port latch, sck_drive is 0, and irq follows the interrupt pin.
- R2: wr_en loads wr_data into the data register while idle, and rd_data shows it. wr_en is ignored while a transfer is busy.
- R3: With the wide bit set, a transfer sends data bits 7 down to 0 (MSB first). The first received bit ends in bit 7 and the last in bit 0.
- R4: With the wide bit clear, only bits 3..0 take part: bit 3 is sent first and the received bits land in 3..0. Bits 7..4 keep their value.
- R5: With the internal clock, each bit period is HALF=32 cycles of clock low followed by 32 cycles high. The first low cycle is the cycle after the start is sampled. The clock pad idles high and sck_drive is 1.
- R6: The serial output takes its next bit when the clock falls. The serial input is captured when the clock rises.
- R7: With the external clock, pad 2 outputs 1 (released) and sck_drive is 0. Shifting happens only on edges of sck_pad_in after a two-flop synchroniser. Without edges, the transfer makes no progress.
- R8: done rises in the cycle after the last internal bit period ends (after 64·N cycles), or after the last synchronised external rising edge, with busy then 0. done stays set until done_clr or an accepted start.
- R9: Mode bit 3 selects the interrupt source: 0 gives irq = NOT int_pad_n, 1 gives irq = done.
- R10: start is ignored while mode bit 0 (enable) is 0 or while busy. Mode writes (cfg_we) are ignored while busy.
- R11: The mode field is bit 0 enable, bit 1 wide, bit 2 external clock, bit 3 interrupt select. With enable 0, pad_out equals port_out. With enable 1: pad 0 = 1, pad 1 = serial data, pad 2 = clock (or 1 if external), pad 3 = port_out[3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one cycle per instruction cycle) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the mode field |
| cfg_wdata | input | 4 | New mode field value |
| wr_en | input | 1 | Parallel load strobe |
| wr_data | input | DW | Parallel load value |
| start | input | 1 | Begin a transfer |
| done_clr | input | 1 | Clear the completion flag |
| rd_data | output | DW | Data register contents |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request after the source selector |
| port_out | input | 4 | General-purpose port output latch |
| pad_out | output | 4 | Values driven onto the shared pads |
| sin_pad | input | 1 | Serial data input pad |
| sck_pad_in | input | 1 | Serial clock pad as read back |
| int_pad_n | input | 1 | External interrupt pad, active low |
| sck_drive | output | 1 | High when the block drives the clock pad |

## Verification
The bench checks the serial output in every bit period against the expected MSB-first bit. A design that shifts on the wrong edge or in the wrong order shows the wrong bit at the first falling edge. In 4-bit transfers it checks that the upper nibble survives both the transfer and a parallel write made in the middle of it; a design that shifts all eight lanes or accepts the write corrupts that nibble. It measures the clock low and high phases and the exact cycle in which done rises, so an off-by-one in the phase counter shows up. It also stalls an external-clock transfer with no edges, which a design that free-runs would complete. Mode writes and restarts during a busy transfer, and the interrupt selector in both positions, show whether the mode field is locked while busy and whether the interrupt source is switched.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2,
        S_EXT  = 2'd3
    } sio_state_t;

    typedef struct packed {
        logic irq_from_done;
        logic ext_clk;
        logic wide;
        logic enable;
    } sio_mode_t;
endpackage

// File: rtl/sio_edge.sv
module sio_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [2:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], pin};
    end

    assign rise = sync_q[1] & ~sync_q[2];
    assign fall = ~sync_q[1] & sync_q[2];
endmodule

// File: rtl/sio_shreg.sv
module sio_shreg #(
    parameter int DW = 8,
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          wide,
    input  logic          shift,
    input  logic          present,
    input  logic          sin,
    output logic [DW-1:0] data,
    output logic          sout
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        localparam bit NARROW_LANE = (i < NW);
        logic in_bit;
        logic en;
        logic qb;
        if (i == 0) begin : g_head
            assign in_bit = sin;
        end else begin : g_chain
            assign in_bit = data[i-1];
        end
        assign en = shift && (NARROW_LANE || wide);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    qb <= 1'b0;
            else if (load) qb <= load_data[i];
            else if (en)   qb <= in_bit;
        end
        assign data[i] = qb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sout <= 1'b1;
        else if (present) sout <= wide ? data[DW-1] : data[NW-1];
    end
endmodule

// File: rtl/sio_fsm.sv
module sio_fsm
    import sio_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NW   = 4,
    parameter int HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic ext_clk,
    input  logic wide,
    input  logic ext_rise,
    input  logic ext_fall,
    input  logic done_clr,
    output logic busy,
    output logic done,
    output logic sck_int,
    output logic present,
    output logic shift
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = $clog2(DW + 1);

    sio_state_t state, nxt;
    logic [CW-1:0] phase;
    logic [BW-1:0] bitcnt;
    logic [BW-1:0] nbits;
    logic          phase_end;
    logic          last;

    assign nbits     = wide ? BW'(DW) : BW'(NW);
    assign phase_end = (phase == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt     = state;
        present = 1'b0;
        shift   = 1'b0;
        last    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (go) begin
                    if (ext_clk) begin
                        nxt = S_EXT;
                    end else begin
                        nxt     = S_LOW;
                        present = 1'b1;
                    end
                end
            end
            S_LOW: begin
                if (phase_end) begin
                    nxt   = S_HIGH;
                    shift = 1'b1;
                end
            end
            S_HIGH: begin
                if (phase_end) begin
                    if (bitcnt == nbits) begin
                        nxt  = S_IDLE;
                        last = 1'b1;
                    end else begin
                        nxt     = S_LOW;
                        present = 1'b1;
                    end
                end
            end
            S_EXT: begin
                present = ext_fall;
                shift   = ext_rise;
                if (ext_rise && (bitcnt == nbits - BW'(1))) begin
                    nxt  = S_IDLE;
                    last = 1'b1;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= '0;
            bitcnt <= '0;
            done   <= 1'b0;
        end else begin
            if (state == S_IDLE || nxt != state) phase <= '0;
            else                                 phase <= phase + CW'(1);
            if (state == S_IDLE)  bitcnt <= '0;
            else if (shift)       bitcnt <= bitcnt + BW'(1);
            if (last)                 done <= 1'b1;
            else if (go || done_clr)  done <= 1'b0;
        end
    end

    assign busy    = (state != S_IDLE);
    assign sck_int = (state != S_LOW);
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NW   = 4,
    parameter int HALF = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_wdata,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          start,
    input  logic          done_clr,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          irq,
    input  logic [3:0]    port_out,
    output logic [3:0]    pad_out,
    input  logic          sin_pad,
    input  logic          sck_pad_in,
    input  logic          int_pad_n,
    output logic          sck_drive
);
    sio_mode_t mode_q;
    logic mode_en, mode_wide, mode_ext, mode_irq;
    logic go, ext_rise, ext_fall, sck_int, present, shift, sout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               mode_q <= '0;
        else if (cfg_we && !busy) mode_q <= sio_mode_t'(cfg_wdata);
    end

    assign mode_en   = mode_q.enable;
    assign mode_wide = mode_q.wide;
    assign mode_ext  = mode_q.ext_clk;
    assign mode_irq  = mode_q.irq_from_done;
    assign go        = start && mode_en && !busy;

    sio_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (sck_pad_in),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    sio_fsm #(.DW(DW), .NW(NW), .HALF(HALF)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .ext_clk (mode_ext),
        .wide    (mode_wide),
        .ext_rise(ext_rise),
        .ext_fall(ext_fall),
        .done_clr(done_clr),
        .busy    (busy),
        .done    (done),
        .sck_int (sck_int),
        .present (present),
        .shift   (shift)
    );

    sio_shreg #(.DW(DW), .NW(NW)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en && !busy),
        .load_data(wr_data),
        .wide     (mode_wide),
        .shift    (shift),
        .present  (present),
        .sin      (sin_pad),
        .data     (rd_data),
        .sout     (sout)
    );

    always_comb begin
        pad_out = port_out;
        if (mode_en) begin
            pad_out[0] = 1'b1;
            pad_out[1] = sout;
            pad_out[2] = mode_ext ? 1'b1 : sck_int;
        end
    end

    assign sck_drive = mode_en && !mode_ext;
    assign irq       = mode_irq ? done : !int_pad_n;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_en,
    input logic       mode_ext,
    input logic       mode_wide,
    input logic       mode_irq,
    input logic       busy,
    input logic       done,
    input logic       done_clr,
    input logic       start,
    input logic       irq,
    input logic       int_pad_n,
    input logic [3:0] pad_out,
    input logic [3:0] port_out,
    input logic       sck_drive
);
    p_port_passthru_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |-> pad_out == port_out);
    p_sck_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && mode_ext) |-> (pad_out[2] && !sck_drive));
    p_sck_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && !mode_ext && !busy) |-> pad_out[2]);
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr && !start) |=> done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);
    p_irq_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_irq |-> irq == done);
    p_irq_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_irq |-> irq == !int_pad_n);
    p_mode_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({mode_en, mode_ext, mode_wide, mode_irq}));
endmodule

bind sio_port sio_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_en  (mode_en),
    .mode_ext (mode_ext),
    .mode_wide(mode_wide),
    .mode_irq (mode_irq),
    .busy     (busy),
    .done     (done),
    .done_clr (done_clr),
    .start    (start),
    .irq      (irq),
    .int_pad_n(int_pad_n),
    .pad_out  (pad_out),
    .port_out (port_out),
    .sck_drive(sck_drive)
);

// File: tb/test_sio_port.sv
module test_sio_port;
    localparam int HALF = 32;
    localparam int EXT_HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_wdata = 4'h0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic start = 1'b0;
    logic done_clr = 1'b0;
    logic [7:0] rd_data;
    logic busy, done, irq, sck_drive;
    logic [3:0] port_out = 4'b1010;
    logic [3:0] pad_out;
    logic sin_pad = 1'b1;
    logic sck_pad_in = 1'b1;
    logic int_pad_n = 1'b1;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    sio_port i_sio_port (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wr_en(wr_en), .wr_data(wr_data), .start(start), .done_clr(done_clr),
        .rd_data(rd_data), .busy(busy), .done(done), .irq(irq),
        .port_out(port_out), .pad_out(pad_out), .sin_pad(sin_pad),
        .sck_pad_in(sck_pad_in), .int_pad_n(int_pad_n), .sck_drive(sck_drive)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] d, input logic [7:0] rx, input bit wide);
        return wide ? rx : {d[7:4], rx[3:0]};
    endfunction

    function automatic logic exp_tx(input logic [7:0] d, input bit wide, input int k);
        return wide ? d[7-k] : d[3-k];
    endfunction

    task automatic cfg_write(input logic [3:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic load(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic int_xfer(input logic [7:0] d, input logic [7:0] rx, input bit wide, input bit poke);
        int nb;
        nb = wide ? 8 : 4;
        cfg_write({1'b0, 1'b0, wide, 1'b1});
        load(d);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R5 busy after start", busy, 1);
        for (int k = 0; k < nb; k++) begin
            if (k > 0) @(negedge clk);
            sin_pad = wide ? rx[7-k] : rx[3-k];
            chk(pad_out[2] == 1'b0, "R5 clock low at period start", pad_out[2], 0);
            chk(pad_out[1] == exp_tx(d, wide, k), "R3 R4 R6 serial out bit", pad_out[1], exp_tx(d, wide, k));
            if (poke && k == 1) begin
                wr_en = 1'b1; wr_data = ~d; cfg_we = 1'b1; cfg_wdata = 4'b1000; start = 1'b1;
                @(negedge clk);
                wr_en = 1'b0; cfg_we = 1'b0; start = 1'b0;
                repeat (HALF - 2) @(negedge clk);
            end else begin
                repeat (HALF - 1) @(negedge clk);
            end
            chk(pad_out[2] == 1'b0, "R5 clock low at last low cycle", pad_out[2], 0);
            @(negedge clk);
            chk(pad_out[2] == 1'b1, "R5 clock high after 32 cycles", pad_out[2], 1);
            repeat (HALF - 1) @(negedge clk);
        end
        chk(done == 1'b0, "R8 done not early", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R8 done after 64N cycles", done, 1);
        chk(busy == 1'b0, "R8 idle at done", busy, 0);
        chk(pad_out[2] == 1'b1, "R5 clock idles high", pad_out[2], 1);
        chk(rd_data == exp_rd(d, rx, wide), "R3 R4 R6 received data", rd_data, exp_rd(d, rx, wide));
        if (poke) begin
            chk(irq == !int_pad_n, "R10 mode write ignored while busy", irq, !int_pad_n);
            chk(rd_data[7:4] == d[7:4], "R2 R4 upper nibble kept", rd_data[7:4], d[7:4]);
        end
    endtask

    task automatic ext_xfer(input logic [7:0] d, input logic [7:0] rx, input bit wide);
        int nb;
        nb = wide ? 8 : 4;
        cfg_write({1'b0, 1'b1, wide, 1'b1});
        load(d);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(pad_out[2] == 1'b1 && sck_drive == 1'b0, "R7 clock pad released", {pad_out[2], sck_drive}, 2'b10);
        repeat (40) @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0, "R7 no progress without edges", {busy, done}, 2'b10);
        for (int k = 0; k < nb; k++) begin
            sck_pad_in = 1'b0;
            sin_pad = wide ? rx[7-k] : rx[3-k];
            repeat (EXT_HALF) @(negedge clk);
            chk(pad_out[1] == exp_tx(d, wide, k), "R7 R6 external serial out bit", pad_out[1], exp_tx(d, wide, k));
            sck_pad_in = 1'b1;
            repeat (EXT_HALF) @(negedge clk);
        end
        chk(done == 1'b1 && busy == 1'b0, "R8 done after last external rise", {done, busy}, 2'b10);
        chk(rd_data == exp_rd(d, rx, wide), "R7 R4 external received data", rd_data, exp_rd(d, rx, wide));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
        chk(pad_out == port_out, "R1 R11 pads follow port", pad_out, port_out);
        chk(sck_drive == 0, "R1 clock not driven", sck_drive, 0);
        chk(irq == 1'b0, "R1 R9 irq follows idle pin", irq, 0);
        int_pad_n = 1'b0;
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq from active pin", irq, 1);
        int_pad_n = 1'b1;

        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R10 start ignored when disabled", busy, 0);

        load(8'hA5);
        chk(rd_data == 8'hA5, "R2 parallel load", rd_data, 8'hA5);

        cfg_write(4'b0011);
        chk(pad_out[0] == 1 && pad_out[2] == 1 && pad_out[3] == port_out[3],
            "R11 serial pad roles", pad_out, {port_out[3], 3'b101});
        chk(sck_drive == 1'b1, "R5 clock pad driven", sck_drive, 1);

        int_xfer(8'hA5, 8'h3C, 1'b1, 1'b0);
        int_xfer(8'h96, 8'h0A, 1'b0, 1'b1);

        repeat (10) @(negedge clk);
        chk(done == 1'b1, "R8 done sticky", done, 1);
        cfg_write(4'b1011);
        chk(irq == 1'b1, "R9 irq from done", irq, 1);
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        chk(done == 1'b0 && irq == 1'b0, "R8 R9 done cleared", {done, irq}, 0);

        int_xfer(8'h5A, 8'hC3, 1'b1, 1'b0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b0 && busy == 1'b1, "R8 start clears done", {done, busy}, 2'b01);
        repeat (8 * 2 * HALF + 4) @(negedge clk);

        ext_xfer(8'hC6, 8'h59, 1'b1);
        ext_xfer(8'h3B, 8'h0D, 1'b0);

        for (int it = 0; it < 8; it++) begin
            logic [7:0] d, rx;
            bit w, e;
            d = 8'($urandom);
            rx = 8'($urandom);
            w = 1'($urandom);
            e = 1'($urandom);
            if (e) ext_xfer(d, rx, w);
            else   int_xfer(d, rx, w, 1'b0);
        end

        cfg_write(4'b0000);
        chk(pad_out == port_out, "R11 pads back to port", pad_out, port_out);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule